// File: doc/BRIEF.md
# Block-Length SPI Master

This block is a memory-mapped SPI master that moves a software-chosen number of bytes between a 32-bit data port and an SPI slave. Software sets a byte count, picks a serial clock rate and a direction in the control register, and starts the transfer by setting the go bit. The block then clocks the bytes over SCK, MOSI and MISO in SPI mode 0, most significant bit first. Data passes through a four-word FIFO, four bytes per word, with the first byte in the low lane.

Chip select is asserted by the go bit and stays asserted after the transfer ends. Several transfers can therefore form one transaction, for example a command followed by a data phase. Chip select is released only when software writes zero to the select register. A one-cycle pulse on `xfer_done` goes to the interrupt logic each time a transfer completes.

The bus is a simple single-cycle register port. Read data is combinational and valid in the same cycle as `reg_rd`. Word addresses: 0 = control, 1 = select, 2 = length, 3 = data, 4 = status. Any other address reads zero.

Top module: `spi_lenx_master`

## Requirements
- R1: After reset, `spi_cs_n` is 1 and `spi_sck` is 0, and the control, select, length and status registers all read 0.
- R2: A control write (address 0) with bit 15 set, made while idle, loads rate (bits 2..0), mode (bit 12) and direction (bit 13, 1 = write to the device) and starts a transfer. Bit 15 reads 1 while the transfer runs and 0 once it ends. Control writes made while a transfer runs have no effect.
- R3: A transfer clocks exactly as many bytes as the length register (address 2) held at the go write. A length of zero ends the transfer without any SCK edge.
- R4: SCK idles low and its period is 2^(rate+2) system clocks. MISO is sampled on the rising edge, MOSI changes only while SCK is low, and bits go most significant first. In read mode MOSI sends 0x00.
- R5: FIFO words carry bytes least significant lane first. In read mode a final partial word is zero-padded in its upper lanes. In write mode, lanes beyond the length are never sent. Reading address 3 pops the head word, and reads 0 when the FIFO is empty.
- R6: In write mode, SCK stops while the FIFO is empty and resumes once software pushes a word to address 3.
- R7: In read mode, SCK stops while a completed word cannot enter a full FIFO, so no byte is lost. Status bit 0 (address 4) reads 1 exactly when the FIFO holds 4 words.
- R8: The go write asserts chip select. Select bit 0 (address 1) reads 1 while chip select is asserted, and chip select stays asserted after the transfer ends. Writing 0 to address 1 releases it when idle. The same write during a transfer is ignored.
- R9: `xfer_done` pulses high for exactly one cycle, in the cycle after the busy bit falls.
- R10: The go write empties the FIFO, so words left over from earlier are never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops the FIFO at address 3) |
| reg_addr | input | 3 | Register word address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data to the device |
| spi_miso | input | 1 | Serial data from the device |
| spi_cs_n | output | 1 | Active-low chip select |
| xfer_done | output | 1 | Transfer-finished event pulse |

## Verification
Some properties are checked on every cycle:
- chip select is asserted whenever a transfer runs;
- SCK stays low when idle;
- MOSI holds steady while SCK is high;
- the FIFO level never exceeds its depth;
- the done pulse lasts one cycle and follows the fall of busy;
- chip select rises only after a select write of zero.

Other behaviours only the bench scenarios can show:
- byte order and zero padding in the FIFO words;
- exact byte counts;
- the stalls on an empty or full FIFO;
- the flush on go;
- measured SCK periods for several rates;
- chip select held across back-to-back transfers;
- control and select writes that are ignored during a transfer.

// File: rtl/spi_lenx_pkg.sv
package spi_lenx_pkg;
  localparam int REG_AW = 3;

  localparam logic [REG_AW-1:0] A_CTRL = 3'd0;
  localparam logic [REG_AW-1:0] A_SEL  = 3'd1;
  localparam logic [REG_AW-1:0] A_LEN  = 3'd2;
  localparam logic [REG_AW-1:0] A_DATA = 3'd3;
  localparam logic [REG_AW-1:0] A_STAT = 3'd4;

  localparam int CTRL_GO_BIT   = 15;
  localparam int CTRL_DIR_BIT  = 13;
  localparam int CTRL_MODE_BIT = 12;

  typedef enum logic {
    SQ_IDLE = 1'b0,
    SQ_RUN  = 1'b1
  } seq_state_e;
endpackage

// File: rtl/spi_lenx_fifo.sv
module spi_lenx_fifo #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             push,
  input  logic [WIDTH-1:0] wdata,
  input  logic             pop,
  output logic [WIDTH-1:0] rdata,
  output logic             empty,
  output logic             full,
  output logic [LVL_W-1:0] level
);
  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] wptr_q, wptr_d, rptr_q, rptr_d;
  logic [LVL_W-1:0] lvl_q, lvl_d;
  logic             do_push, do_pop;

  assign empty   = (lvl_q == '0);
  assign full    = (lvl_q == LVL_W'(DEPTH));
  assign level   = lvl_q;
  assign rdata   = mem[rptr_q];
  assign do_push = push && !full && !flush;
  assign do_pop  = pop && !empty && !flush;

  always_comb begin
    wptr_d = wptr_q;
    rptr_d = rptr_q;
    lvl_d  = lvl_q;
    if (flush) begin
      wptr_d = '0;
      rptr_d = '0;
      lvl_d  = '0;
    end else begin
      if (do_push) wptr_d = (wptr_q == PTR_W'(DEPTH - 1)) ? '0 : wptr_q + 1'b1;
      if (do_pop)  rptr_d = (rptr_q == PTR_W'(DEPTH - 1)) ? '0 : rptr_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_d = lvl_q + 1'b1;
        2'b01:   lvl_d = lvl_q - 1'b1;
        default: lvl_d = lvl_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr_q <= '0;
      rptr_q <= '0;
      lvl_q  <= '0;
    end else begin
      wptr_q <= wptr_d;
      rptr_q <= rptr_d;
      lvl_q  <= lvl_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wptr_q] <= wdata;
  end
endmodule

// File: rtl/spi_lenx_shifter.sv
module spi_lenx_shifter #(
  parameter int RATE_W = 3,
  parameter int BYTE_W = 8,
  localparam int CNT_W = (1 << RATE_W) + 1,
  localparam int BIT_W = $clog2(BYTE_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [RATE_W-1:0] rate,
  input  logic              start,
  input  logic [BYTE_W-1:0] tx_byte,
  input  logic              miso,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [BYTE_W-1:0] rx_byte
);
  logic              busy_q, busy_d;
  logic              sck_q, sck_d;
  logic              done_q, done_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d, half_m1;
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [BYTE_W-1:0] tx_q, tx_d, rx_q, rx_d;
  logic              run_en;

  // half period in system clocks is 2^(rate+1)
  assign half_m1 = (CNT_W'(2) << rate) - CNT_W'(1);
  assign run_en  = busy_q || start;

  assign sck     = sck_q;
  assign mosi    = busy_q & tx_q[BYTE_W-1];
  assign busy    = busy_q;
  assign done    = done_q;
  assign rx_byte = rx_q;

  always_comb begin
    busy_d = busy_q;
    sck_d  = sck_q;
    cnt_d  = cnt_q;
    bit_d  = bit_q;
    tx_d   = tx_q;
    rx_d   = rx_q;
    done_d = 1'b0;
    if (!busy_q) begin
      if (start) begin
        busy_d = 1'b1;
        sck_d  = 1'b0;
        cnt_d  = half_m1;
        bit_d  = '0;
        tx_d   = tx_byte;
      end
    end else if (cnt_q == '0) begin
      cnt_d = half_m1;
      if (!sck_q) begin
        sck_d = 1'b1;
        rx_d  = {rx_q[BYTE_W-2:0], miso};
      end else begin
        sck_d = 1'b0;
        if (bit_q == BIT_W'(BYTE_W - 1)) begin
          busy_d = 1'b0;
          done_d = 1'b1;
        end else begin
          bit_d = bit_q + 1'b1;
          tx_d  = {tx_q[BYTE_W-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      sck_q  <= 1'b0;
      done_q <= 1'b0;
      cnt_q  <= '0;
      bit_q  <= '0;
      tx_q   <= '0;
      rx_q   <= '0;
    end else begin
      done_q <= done_d;
      if (run_en) begin
        busy_q <= busy_d;
        sck_q  <= sck_d;
        cnt_q  <= cnt_d;
        bit_q  <= bit_d;
        tx_q   <= tx_d;
        rx_q   <= rx_d;
      end
    end
  end
endmodule

// File: rtl/spi_lenx_seq.sv
module spi_lenx_seq
  import spi_lenx_pkg::*;
#(
  parameter int LEN_W  = 32,
  parameter int WORD_W = 32,
  parameter int BYTE_W = 8,
  localparam int LANES  = WORD_W / BYTE_W,
  localparam int LANE_W = $clog2(LANES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              trigger,
  input  logic              dir_wr,
  input  logic [LEN_W-1:0]  len,
  input  logic [WORD_W-1:0] fifo_rdata,
  input  logic              fifo_empty,
  input  logic              fifo_full,
  input  logic              sh_busy,
  input  logic              sh_done,
  input  logic [BYTE_W-1:0] sh_rx,
  output logic              fifo_pop,
  output logic              fifo_push,
  output logic [WORD_W-1:0] fifo_wdata,
  output logic              sh_start,
  output logic [BYTE_W-1:0] sh_tx,
  output logic              busy,
  output logic              done
);
  seq_state_e        state_q, state_d;
  logic [LEN_W-1:0]  left_q, left_d;
  logic [LANE_W-1:0] lane_q, lane_d;
  logic [WORD_W-1:0] wbuf_q, wbuf_d, rbuf_q, rbuf_d;
  logic              have_q, have_d, pend_q, pend_d, done_q, done_d;
  logic              last_lane;

  assign busy       = (state_q == SQ_RUN);
  assign done       = done_q;
  assign fifo_wdata = rbuf_q;
  assign last_lane  = (lane_q == LANE_W'(LANES - 1));

  always_comb begin
    state_d   = state_q;
    left_d    = left_q;
    lane_d    = lane_q;
    wbuf_d    = wbuf_q;
    rbuf_d    = rbuf_q;
    have_d    = have_q;
    pend_d    = pend_q;
    done_d    = 1'b0;
    fifo_pop  = 1'b0;
    fifo_push = 1'b0;
    sh_start  = 1'b0;
    sh_tx     = '0;
    unique case (state_q)
      SQ_IDLE: begin
        if (trigger) begin
          state_d = SQ_RUN;
          left_d  = len;
          lane_d  = '0;
          have_d  = 1'b0;
          pend_d  = 1'b0;
          rbuf_d  = '0;
        end
      end
      SQ_RUN: begin
        if (sh_done) begin
          left_d = left_q - 1'b1;
          lane_d = lane_q + 1'b1;
          if (!dir_wr) begin
            rbuf_d[lane_q*BYTE_W +: BYTE_W] = sh_rx;
            if (last_lane || left_q == LEN_W'(1)) pend_d = 1'b1;
          end else begin
            wbuf_d = wbuf_q >> BYTE_W;
            if (last_lane) have_d = 1'b0;
          end
        end else if (!sh_busy) begin
          if (!dir_wr) begin
            if (pend_q) begin
              if (!fifo_full) begin
                fifo_push = 1'b1;
                pend_d    = 1'b0;
                rbuf_d    = '0;
              end
            end else if (left_q == '0) begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
            end else begin
              sh_start = 1'b1;
            end
          end else begin
            if (left_q == '0) begin
              state_d = SQ_IDLE;
              done_d  = 1'b1;
            end else if (!have_q) begin
              if (!fifo_empty) begin
                fifo_pop = 1'b1;
                wbuf_d   = fifo_rdata;
                have_d   = 1'b1;
              end
            end else begin
              sh_start = 1'b1;
              sh_tx    = wbuf_q[BYTE_W-1:0];
            end
          end
        end
      end
      default: state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      left_q  <= '0;
      lane_q  <= '0;
      wbuf_q  <= '0;
      rbuf_q  <= '0;
      have_q  <= 1'b0;
      pend_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      left_q  <= left_d;
      lane_q  <= lane_d;
      wbuf_q  <= wbuf_d;
      rbuf_q  <= rbuf_d;
      have_q  <= have_d;
      pend_q  <= pend_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/spi_lenx_master.sv
module spi_lenx_master
  import spi_lenx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int LEN_W      = 32,
  parameter int FIFO_DEPTH = 4,
  parameter int RATE_W     = 3,
  localparam int BYTE_W = 8,
  localparam int LVL_W  = $clog2(FIFO_DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              spi_cs_n,
  output logic              xfer_done
);
  logic [RATE_W-1:0] rate_q, rate_d;
  logic              dir_q, dir_d, mode_q, mode_d, sel_q, sel_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              busy, trig, ctrl_wr;

  logic              eng_pop, eng_push, sw_pop, sw_push;
  logic [DATA_W-1:0] eng_wdata, fifo_rdata, fifo_wdata;
  logic              fifo_empty, fifo_full;
  logic [LVL_W-1:0]  fifo_lvl;

  logic              sh_start, sh_busy, sh_done;
  logic [BYTE_W-1:0] sh_tx, sh_rx;

  assign ctrl_wr = reg_wr && (reg_addr == A_CTRL) && !busy;
  assign trig    = ctrl_wr && reg_wdata[CTRL_GO_BIT];
  assign sw_push = reg_wr && (reg_addr == A_DATA) && dir_q;
  assign sw_pop  = reg_rd && (reg_addr == A_DATA);

  always_comb begin
    rate_d = rate_q;
    dir_d  = dir_q;
    mode_d = mode_q;
    sel_d  = sel_q;
    len_d  = len_q;
    if (ctrl_wr) begin
      rate_d = reg_wdata[RATE_W-1:0];
      dir_d  = reg_wdata[CTRL_DIR_BIT];
      mode_d = reg_wdata[CTRL_MODE_BIT];
    end
    if (trig) begin
      sel_d = 1'b1;
    end else if (reg_wr && (reg_addr == A_SEL) && !reg_wdata[0] && !busy) begin
      sel_d = 1'b0;
    end
    if (reg_wr && (reg_addr == A_LEN)) len_d = reg_wdata[LEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rate_q <= '0;
      dir_q  <= 1'b0;
      mode_q <= 1'b0;
      sel_q  <= 1'b0;
      len_q  <= '0;
    end else begin
      rate_q <= rate_d;
      dir_q  <= dir_d;
      mode_q <= mode_d;
      sel_q  <= sel_d;
      len_q  <= len_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      A_CTRL: begin
        reg_rdata[RATE_W-1:0]    = rate_q;
        reg_rdata[CTRL_MODE_BIT] = mode_q;
        reg_rdata[CTRL_DIR_BIT]  = dir_q;
        reg_rdata[CTRL_GO_BIT]   = busy;
      end
      A_SEL:   reg_rdata[0] = sel_q;
      A_LEN:   reg_rdata[LEN_W-1:0] = len_q;
      A_DATA:  reg_rdata = fifo_empty ? '0 : fifo_rdata;
      A_STAT:  reg_rdata[0] = fifo_full;
      default: reg_rdata = '0;
    endcase
  end

  assign fifo_wdata = eng_push ? eng_wdata : reg_wdata;

  spi_lenx_fifo #(
    .WIDTH (DATA_W),
    .DEPTH (FIFO_DEPTH)
  ) u_fifo (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (trig),
    .push  (sw_push | eng_push),
    .wdata (fifo_wdata),
    .pop   (sw_pop | eng_pop),
    .rdata (fifo_rdata),
    .empty (fifo_empty),
    .full  (fifo_full),
    .level (fifo_lvl)
  );

  spi_lenx_seq #(
    .LEN_W  (LEN_W),
    .WORD_W (DATA_W),
    .BYTE_W (BYTE_W)
  ) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .trigger    (trig),
    .dir_wr     (dir_q),
    .len        (len_q),
    .fifo_rdata (fifo_rdata),
    .fifo_empty (fifo_empty),
    .fifo_full  (fifo_full),
    .sh_busy    (sh_busy),
    .sh_done    (sh_done),
    .sh_rx      (sh_rx),
    .fifo_pop   (eng_pop),
    .fifo_push  (eng_push),
    .fifo_wdata (eng_wdata),
    .sh_start   (sh_start),
    .sh_tx      (sh_tx),
    .busy       (busy),
    .done       (xfer_done)
  );

  spi_lenx_shifter #(
    .RATE_W (RATE_W),
    .BYTE_W (BYTE_W)
  ) u_shift (
    .clk     (clk),
    .rst_n   (rst_n),
    .rate    (rate_q),
    .start   (sh_start),
    .tx_byte (sh_tx),
    .miso    (spi_miso),
    .sck     (spi_sck),
    .mosi    (spi_mosi),
    .busy    (sh_busy),
    .done    (sh_done),
    .rx_byte (sh_rx)
  );

  assign spi_cs_n = ~sel_q;
endmodule

// File: rtl/spi_lenx_master_chk.sv
module spi_lenx_master_chk
  import spi_lenx_pkg::*;
#(
  parameter int FIFO_DEPTH = 4,
  parameter int LVL_W      = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              spi_sck,
  input logic              spi_mosi,
  input logic              spi_cs_n,
  input logic              xfer_done,
  input logic [LVL_W-1:0]  fifo_lvl,
  input logic              reg_wr,
  input logic [REG_AW-1:0] reg_addr,
  input logic              reg_wdata0
);
  assert_cs_while_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !spi_cs_n);

  assert_cs_release_by_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(spi_cs_n) |-> $past(reg_wr && (reg_addr == A_SEL) && !reg_wdata0));

  assert_sck_idle_low_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !spi_sck);

  assert_mosi_hold_high_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (spi_sck && $past(spi_sck)) |-> $stable(spi_mosi));

  assert_fifo_bound_R7: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_lvl <= LVL_W'(FIFO_DEPTH));

  assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> (!busy && $past(busy)));

  assert_done_one_cycle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);
endmodule

bind spi_lenx_master spi_lenx_master_chk #(
  .FIFO_DEPTH (FIFO_DEPTH),
  .LVL_W      (LVL_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .spi_sck    (spi_sck),
  .spi_mosi   (spi_mosi),
  .spi_cs_n   (spi_cs_n),
  .xfer_done  (xfer_done),
  .fifo_lvl   (fifo_lvl),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata0 (reg_wdata[0])
);

// File: tb/spi_lenx_master_tb.sv
`timescale 1ns/1ps
module spi_lenx_master_tb;
  logic        clk;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        spi_sck, spi_mosi, spi_miso, spi_cs_n, xfer_done;

  int tests = 0;
  int fails = 0;
  int done_cnt = 0;
  int byte_cnt = 0;
  int cs_rise_cnt = 0;
  int per_cyc = 0;

  logic [7:0] exp_mosi[$];
  logic [7:0] miso_q[$];
  logic [7:0] sl_tx, sl_rx;
  int         sl_bit;
  realtime    last_rise;

  spi_lenx_master u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .spi_sck(spi_sck), .spi_mosi(spi_mosi), .spi_miso(spi_miso),
    .spi_cs_n(spi_cs_n), .xfer_done(xfer_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // slave model and scoreboard monitor
  assign spi_miso = sl_tx[7];

  always @(negedge spi_cs_n) begin
    sl_bit = 0;
    sl_tx  = (miso_q.size() > 0) ? miso_q.pop_front() : 8'h00;
  end

  always @(posedge spi_cs_n) cs_rise_cnt++;

  always @(posedge spi_sck) begin
    if (sl_bit != 0) per_cyc = int'(($realtime - last_rise) / 5.0);
    last_rise = $realtime;
    sl_rx  = {sl_rx[6:0], spi_mosi};
    sl_tx  = {sl_tx[6:0], 1'b0};
    sl_bit = sl_bit + 1;
    if (sl_bit == 8) begin
      sl_bit = 0;
      byte_cnt++;
      if (exp_mosi.size() == 0) check("R3 unexpected byte", {24'h0, sl_rx}, 32'hxxxxxxxx);
      else check("R4 mosi byte", {24'h0, sl_rx}, {24'h0, exp_mosi.pop_front()});
      sl_tx = (miso_q.size() > 0) ? miso_q.pop_front() : 8'h00;
    end
  end

  always @(negedge clk) if (xfer_done) done_cnt++;

  task automatic reg_write(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(posedge clk); #1;
    reg_wr = 1'b0;
  endtask

  task automatic reg_read(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(posedge clk); #1;
    reg_rd = 1'b0;
  endtask

  task automatic wait_idle(input string tag);
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_read(3'd0, v);
      if (!v[15]) return;
    end
    check({tag, " timeout"}, 32'd1, 32'd0);
  endtask

  initial begin
    logic [31:0] v;
    int d0;
    reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    sl_tx = 0; sl_rx = 0; sl_bit = 0; last_rise = 0;
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    @(negedge clk);
    check("R1 cs_n", spi_cs_n, 1);
    check("R1 sck", spi_sck, 0);
    reg_read(3'd0, v); check("R1 ctrl", v, 0);
    reg_read(3'd1, v); check("R1 sel", v, 0);
    reg_read(3'd2, v); check("R1 len", v, 0);
    reg_read(3'd4, v); check("R1 stat", v, 0);

    // write 6 bytes, rate 0; lanes beyond length ignored (R5)
    byte_cnt = 0; d0 = done_cnt;
    reg_write(3'd2, 6);
    reg_write(3'd0, 32'h0000_A000);
    reg_read(3'd0, v); check("R2 busy after go", v, 32'h0000_A000);
    check("R8 cs asserted", spi_cs_n, 0);
    for (int b = 1; b <= 6; b++) exp_mosi.push_back(8'(b * 8'h11));
    reg_write(3'd3, 32'h4433_2211);
    reg_write(3'd3, 32'hAABB_6655);
    wait_idle("R2 write6");
    repeat (20) @(negedge clk);
    check("R3 six bytes", byte_cnt, 6);
    check("R9 one done pulse", done_cnt - d0, 1);
    check("R4 period rate0", per_cyc, 4);
    reg_read(3'd1, v); check("R8 sel held", v, 1);
    check("R8 cs held after done", spi_cs_n, 0);
    reg_write(3'd1, 0);
    @(negedge clk);
    check("R8 cs released", spi_cs_n, 1);
    reg_read(3'd1, v); check("R8 sel cleared", v, 0);

    // read 22 bytes at rate 1, stall on full FIFO (R7, R5)
    byte_cnt = 0;
    for (int b = 1; b <= 22; b++) begin
      miso_q.push_back(8'(b));
      exp_mosi.push_back(8'h00);
    end
    reg_write(3'd2, 22);
    reg_write(3'd0, 32'h0000_8001);
    for (int i = 0; i < 5000 && byte_cnt < 20; i++) @(negedge clk);
    repeat (300) @(negedge clk);
    check("R7 stalled at 20 bytes", byte_cnt, 20);
    reg_read(3'd4, v); check("R7 full flag", v, 1);
    reg_read(3'd0, v); check("R7 still busy", v[15], 1);
    for (int w = 0; w < 4; w++) begin
      reg_read(3'd3, v);
      check("R5 read word", v, {8'(4*w+4), 8'(4*w+3), 8'(4*w+2), 8'(4*w+1)});
    end
    wait_idle("R7 read22");
    check("R4 period rate1", per_cyc, 8);
    reg_read(3'd3, v); check("R5 word5", v, 32'h1413_1211);
    reg_read(3'd3, v); check("R5 padded word", v, 32'h0000_1615);
    reg_read(3'd3, v); check("R5 empty read", v, 0);
    check("R3 22 bytes", byte_cnt, 22);

    // second transfer within same selection, rate 2
    d0 = cs_rise_cnt; byte_cnt = 0;
    reg_write(3'd2, 2);
    reg_write(3'd0, 32'h0000_A002);
    exp_mosi.push_back(8'hA5); exp_mosi.push_back(8'hC3);
    reg_write(3'd3, 32'h0000_C3A5);
    wait_idle("R8 chained");
    check("R8 cs held across transfers", cs_rise_cnt - d0, 0);
    check("R4 period rate2", per_cyc, 16);
    check("R3 two bytes", byte_cnt, 2);
    reg_write(3'd1, 0);

    // flush on go, empty stall, ignored writes while busy
    reg_write(3'd0, 32'h0000_2000);
    for (int w = 0; w < 4; w++) reg_write(3'd3, 32'hEEEE_EEEE);
    reg_read(3'd4, v); check("R7 full after 4 pushes", v, 1);
    byte_cnt = 0;
    reg_write(3'd2, 4);
    reg_write(3'd0, 32'h0000_A000);
    reg_read(3'd4, v); check("R10 flushed", v, 0);
    repeat (300) @(negedge clk);
    check("R6 no sck while empty", byte_cnt, 0);
    reg_write(3'd1, 0);
    @(negedge clk);
    check("R8 select write ignored busy", spi_cs_n, 0);
    reg_write(3'd0, 32'h0000_1007);
    reg_read(3'd0, v); check("R2 ctrl write ignored busy", v, 32'h0000_A000);
    for (int b = 0; b < 4; b++) exp_mosi.push_back(8'(8'h0A + b));
    reg_write(3'd3, 32'h0D0C_0B0A);
    wait_idle("R6 resume");
    check("R6 resumed 4 bytes", byte_cnt, 4);
    reg_write(3'd1, 0);

    // zero length
    byte_cnt = 0; d0 = done_cnt;
    reg_write(3'd2, 0);
    reg_write(3'd0, 32'h0000_8000);
    wait_idle("R3 zero");
    repeat (4) @(negedge clk);
    check("R3 zero length no bytes", byte_cnt, 0);
    check("R9 zero length done", done_cnt - d0, 1);
    check("R3 scoreboard drained", exp_mosi.size(), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog R2 actual=hung expected=finished");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule